// File: doc/BRIEF.md
# Multiplexed Bus Read Strobe Sequencer

This block runs read transactions on a shared address/data parallel bus that serves NOR-flash-like memories and FPGA peripherals. A request carries a start address, a beat count and a set of timing fields, each given in clock cycles. The block first drives the address for one cycle with the address latch strobe high. It then selects the device, opens the output enable, and captures the incoming data at the programmed points. Each captured word is returned with a one-cycle valid pulse.

Every strobe edge has its own delay. These are the gap to the first capture, the gap between later captures, the delay from select to output enable, the select hold after the final capture, and a quiet period during which the controller keeps off the shared bus. The three low address lines step once per beat. A skew field sets how early each step happens ahead of the next capture, so that pipelined synchronous parts can be served. The address and the timing fields are taken at acceptance. The block reports busy from acceptance until the quiet period has run out.

Cycle numbering below: cycle k=0 is the first cycle after the latch cycle. The latch cycle is k=-1, and it is the cycle right after the request is sampled. Capture i of a burst happens in cycle s_i = F + i*G, where F is the first-capture field and G is the next-beat field (a value of 0 is used as 1). The last capture is at LS. M is the larger of the hold field H and the turn-off field T.

Top module: `pbr_rd_seq`

## Requirements
- R1: After reset, and after a reset applied in the middle of a transfer, the outputs read: latch low, select high (inactive), output enable high (inactive), address drive off, busy low, read-valid low.
- R2: A request sampled while idle produces one latch cycle (k=-1). In that cycle the latch strobe and the address drive are high, the full address appears on the address output, the low lines equal address bits [2:0], and select is still high. Select goes low at k=0.
- R3: The first capture occurs at k=F (F=0 captures at k=0). The captured word appears on the read data port with read-valid high in the following cycle.
- R4: A burst of B beats (request length field = B-1) captures at s_i for i=0..B-1 and produces exactly B read-valid pulses, each one cycle after its capture.
- R5: Output enable (active low) goes low at k=S, where S is the setup field, and stays low through LS. With S=0 it falls in the same cycle as select. S does not move the first capture.
- R6: Output enable returns high at LS+1 whatever the hold field is.
- R7: Select stays low through k=LS+H and is high from LS+H+1. With H=0 it returns high together with output enable.
- R8: Busy is high from k=-1 through LS+M and low from LS+M+1. The address drive is low in every cycle from k=0 on.
- R9: The low address lines step by one (modulo 8) between beats. The step after capture i shows up at cycle max(s_i+1, s_(i+1)-K), where K is the skew field.
- R10: A request presented while busy is ignored. No new latch cycle follows, and busy drops at LS+M+1 as if no request had been made.
- R11: Address, length and timing fields are sampled only at acceptance. Changing them while busy leaves every strobe and capture position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request, sampled while idle |
| req_addr | input | ADDR_W | Start address |
| req_len | input | LEN_W | Beats in the burst minus one |
| cfg_first | input | TW | Cycles from latch release to first capture |
| cfg_next | input | TW | Cycles between captures (0 acts as 1) |
| cfg_setup | input | TW | Cycles from select to output enable |
| cfg_hold | input | TW | Select hold after last capture |
| cfg_turn | input | TW | Quiet cycles after last capture |
| cfg_skew | input | TW | Cycles the low-line step leads the next capture |
| bus_din | input | DATA_W | Data read from the shared bus |
| bus_ale | output | 1 | Address latch strobe |
| bus_cs_n | output | 1 | Device select, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_lane | output | LANE_W | Low address lines |
| bus_aout | output | ADDR_W | Address driven in the latch cycle |
| bus_aout_en | output | 1 | Controller drives the shared bus |
| busy | output | 1 | Transfer or quiet period in progress |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DATA_W | Captured read word |

## Verification
The timing table is run with several patterns. One uses zero first-capture, setup, hold and turn-off with a single beat, which shows that every edge falls together as stated. One uses a zero next-beat gap, which shows the value is treated as one and that the low lines wrap from 7. Another pair sets the skew below the beat gap and then above it, which separates the early low-line step from the step right after a capture. A hold longer than the turn-off period shows that busy follows the larger of the two. A noisy run holds a second request and different field values on the inputs throughout a burst. It shows that these inputs are ignored and that the fields were latched at acceptance. A reset in the middle of a burst confirms the return to idle.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_ACC  = 2'd2,
        ST_POST = 2'd3
    } pbr_state_e;

    localparam int unsigned POST_NUM = 2;
    localparam int unsigned POST_HOLD = 0;
    localparam int unsigned POST_TURN = 1;

endpackage

// File: rtl/pbr_dncnt.sv
module pbr_dncnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_o,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pbr_lane_step.sv
module pbr_lane_step #(
    parameter int unsigned LANE_W = 3,
    parameter int unsigned TW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LANE_W-1:0] load_val,
    input  logic              beat_sample,
    input  logic              wait_active,
    input  logic [TW-1:0]     wait_cnt,
    input  logic [TW-1:0]     gap_m1,
    input  logic [TW-1:0]     skew,
    output logic [LANE_W-1:0] lane_o
);
    logic [LANE_W-1:0] lane_d, lane_q;
    logic [TW:0]       lead_pt;
    logic              step_now;

    always_comb begin
        lead_pt  = {1'b0, skew} + (TW+1)'(1);
        // skew reaching the whole gap: step right after the capture
        step_now = (beat_sample && (skew >= gap_m1)) ||
                   (wait_active && ({1'b0, wait_cnt} == lead_pt));
        lane_d = lane_q;
        if (load)
            lane_d = load_val;
        else if (step_now)
            lane_d = lane_q + LANE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    assign lane_o = lane_q;
endmodule

// File: rtl/pbr_rd_seq.sv
module pbr_rd_seq
    import pbr_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LEN_W  = 4,
    parameter int unsigned TW     = 8,
    parameter int unsigned LANE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [TW-1:0]     cfg_first,
    input  logic [TW-1:0]     cfg_next,
    input  logic [TW-1:0]     cfg_setup,
    input  logic [TW-1:0]     cfg_hold,
    input  logic [TW-1:0]     cfg_turn,
    input  logic [TW-1:0]     cfg_skew,
    input  logic [DATA_W-1:0] bus_din,
    output logic              bus_ale,
    output logic              bus_cs_n,
    output logic              bus_oe_n,
    output logic [LANE_W-1:0] bus_lane,
    output logic [ADDR_W-1:0] bus_aout,
    output logic              bus_aout_en,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [TW-1:0] ONE_T = TW'(1);

    typedef struct packed {
        pbr_state_e        state;
        logic [TW-1:0]     cnt;
        logic [TW-1:0]     oe_cnt;
        logic [TW-1:0]     gap_m1;
        logic [TW-1:0]     skew;
        logic [TW-1:0]     hold;
        logic [TW-1:0]     turn;
        logic [LEN_W-1:0]  left;
        logic              burst;
        logic [ADDR_W-1:0] addr;
        logic              vld;
        logic [DATA_W-1:0] data;
    } seq_t;

    seq_t s_d, s_q;

    logic              sample_now;
    logic              last_now;
    logic              accept;
    logic              post_load;
    logic [TW-1:0]     post_val  [POST_NUM];
    logic [TW-1:0]     post_cnt  [POST_NUM];
    logic              post_zero [POST_NUM];

    assign sample_now = (s_q.state == ST_ACC) && (s_q.cnt == '0);
    assign last_now   = sample_now && (s_q.left == '0);
    assign accept     = (s_q.state == ST_IDLE) && req_valid;
    assign post_load  = last_now;
    assign post_val[POST_HOLD] = s_q.hold;
    assign post_val[POST_TURN] = s_q.turn;

    for (genvar g = 0; g < POST_NUM; g++) begin : g_post
        pbr_dncnt #(.W(TW)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (post_load),
            .load_val (post_val[g]),
            .cnt_o    (post_cnt[g]),
            .zero_o   (post_zero[g])
        );
    end

    pbr_lane_step #(.LANE_W(LANE_W), .TW(TW)) u_lane (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept),
        .load_val    (req_addr[LANE_W-1:0]),
        .beat_sample (sample_now && (s_q.left != '0)),
        .wait_active ((s_q.state == ST_ACC) && s_q.burst && (s_q.cnt != '0)),
        .wait_cnt    (s_q.cnt),
        .gap_m1      (s_q.gap_m1),
        .skew        (s_q.skew),
        .lane_o      (bus_lane)
    );

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.state  = ST_ADDR;
                    s_d.cnt    = cfg_first;
                    s_d.oe_cnt = cfg_setup;
                    s_d.gap_m1 = (cfg_next == '0) ? '0 : cfg_next - ONE_T;
                    s_d.skew   = cfg_skew;
                    s_d.hold   = cfg_hold;
                    s_d.turn   = cfg_turn;
                    s_d.left   = req_len;
                    s_d.burst  = 1'b0;
                    s_d.addr   = req_addr;
                end
            end
            ST_ADDR: begin
                s_d.state = ST_ACC;
            end
            ST_ACC: begin
                if (s_q.oe_cnt != '0)
                    s_d.oe_cnt = s_q.oe_cnt - ONE_T;
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - ONE_T;
                end else begin
                    s_d.vld  = 1'b1;
                    s_d.data = bus_din;
                    if (s_q.left == '0) begin
                        s_d.state = ((s_q.hold | s_q.turn) != '0) ? ST_POST : ST_IDLE;
                    end else begin
                        s_d.left  = s_q.left - LEN_W'(1);
                        s_d.cnt   = s_q.gap_m1;
                        s_d.burst = 1'b1;
                    end
                end
            end
            ST_POST: begin
                if ((post_cnt[POST_HOLD] <= ONE_T) && (post_cnt[POST_TURN] <= ONE_T))
                    s_d.state = ST_IDLE;
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_ale     = (s_q.state == ST_ADDR);
    assign bus_aout_en = (s_q.state == ST_ADDR);
    assign bus_aout    = s_q.addr;
    assign bus_cs_n    = !((s_q.state == ST_ACC) ||
                           ((s_q.state == ST_POST) && !post_zero[POST_HOLD]));
    assign bus_oe_n    = !((s_q.state == ST_ACC) && (s_q.oe_cnt == '0));
    assign busy        = (s_q.state != ST_IDLE);
    assign rd_valid    = s_q.vld;
    assign rd_data     = s_q.data;
endmodule

// File: rtl/pbr_rd_seq_chk.sv
module pbr_rd_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_ale,
    input logic bus_cs_n,
    input logic bus_oe_n,
    input logic bus_aout_en,
    input logic busy,
    input logic rd_valid
);
    // R2
    ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> !bus_ale);
    // R2
    cs_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> !bus_cs_n);
    // R5
    oe_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_n |-> !bus_cs_n);
    // R8
    drive_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_aout_en |-> (bus_cs_n && busy));
    // R10
    ale_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> $past(!busy));
    // R3
    valid_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!bus_cs_n && !bus_oe_n));
endmodule

bind pbr_rd_seq pbr_rd_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_ale     (bus_ale),
    .bus_cs_n    (bus_cs_n),
    .bus_oe_n    (bus_oe_n),
    .bus_aout_en (bus_aout_en),
    .busy        (busy),
    .rd_valid    (rd_valid)
);

// File: tb/pbr_rd_seq_bench.sv
module pbr_rd_seq_bench;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;
    localparam int LEN_W  = 4;
    localparam int TW     = 8;
    localparam int LANE_W = 3;

    typedef struct packed {
        logic [7:0]  f;
        logic [7:0]  n;
        logic [7:0]  s;
        logic [7:0]  h;
        logic [7:0]  t;
        logic [7:0]  k;
        logic [7:0]  beats;
        logic [23:0] addr;
        logic        noise;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{8'd3, 8'd2, 8'd1, 8'd1, 8'd3, 8'd0, 8'd4, 24'h000105, 1'b0},
        '{8'd0, 8'd1, 8'd0, 8'd0, 8'd0, 8'd0, 8'd1, 24'h000000, 1'b0},
        '{8'd2, 8'd0, 8'd0, 8'd0, 8'd2, 8'd0, 8'd3, 24'h000007, 1'b0},
        '{8'd5, 8'd4, 8'd2, 8'd2, 8'd5, 8'd2, 8'd3, 24'h001236, 1'b0},
        '{8'd4, 8'd3, 8'd3, 8'd0, 8'd1, 8'd5, 8'd2, 24'h0000FE, 1'b0},
        '{8'd1, 8'd1, 8'd0, 8'd3, 8'd1, 8'd0, 8'd2, 24'hABCDE1, 1'b0},
        '{8'd6, 8'd2, 8'd5, 8'd2, 8'd4, 8'd1, 8'd5, 24'h3C0003, 1'b1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic [TW-1:0]     cfg_first = '0, cfg_next = '0, cfg_setup = '0;
    logic [TW-1:0]     cfg_hold = '0, cfg_turn = '0, cfg_skew = '0;
    logic [DATA_W-1:0] bus_din = '0;
    logic              bus_ale, bus_cs_n, bus_oe_n, bus_aout_en, busy, rd_valid;
    logic [LANE_W-1:0] bus_lane;
    logic [ADDR_W-1:0] bus_aout;
    logic [DATA_W-1:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    int wd = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pbr_rd_seq u_pbr_rd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .cfg_first(cfg_first), .cfg_next(cfg_next),
        .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .cfg_turn(cfg_turn),
        .cfg_skew(cfg_skew), .bus_din(bus_din), .bus_ale(bus_ale),
        .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_lane(bus_lane),
        .bus_aout(bus_aout), .bus_aout_en(bus_aout_en), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int lane_exp(vec_t v, int k);
        int g = (v.n == 0) ? 1 : int'(v.n);
        int cnt = 0;
        for (int i = 0; i < int'(v.beats) - 1; i++) begin
            int a = int'(v.f) + i * g + 1;
            int b = int'(v.f) + (i + 1) * g - int'(v.k);
            int c = (a > b) ? a : b;
            if (c <= k) cnt++;
        end
        return (int'(v.addr[2:0]) + cnt) % 8;
    endfunction

    task automatic check_idle(input string tag);
        chk({tag, " ale"}, 32'(bus_ale), 32'd0);
        chk({tag, " cs_n"}, 32'(bus_cs_n), 32'd1);
        chk({tag, " oe_n"}, 32'(bus_oe_n), 32'd1);
        chk({tag, " drive"}, 32'(bus_aout_en), 32'd0);
        chk({tag, " busy"}, 32'(busy), 32'd0);
        chk({tag, " rd_valid"}, 32'(rd_valid), 32'd0);
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int g  = (v.n == 0) ? 1 : int'(v.n);
        int ls = int'(v.f) + (int'(v.beats) - 1) * g;
        int m  = (v.h > v.t) ? int'(v.h) : int'(v.t);
        string sfx = v.noise ? " R10 R11" : "";
        logic [DATA_W-1:0] prev_d;
        // acceptance: drive request at a negedge while idle
        req_valid = 1'b1;
        req_addr  = v.addr;
        req_len   = LEN_W'(int'(v.beats) - 1);
        cfg_first = v.f; cfg_next = v.n; cfg_setup = v.s;
        cfg_hold  = v.h; cfg_turn = v.t; cfg_skew = v.k;
        prev_d    = DATA_W'(16'h5A00 + idx * 256);
        bus_din   = prev_d;
        for (int k = -1; k <= ls + m + 2; k++) begin
            int kk = k - 1;
            bit exp_busy = (k <= ls + m);
            bit exp_vld = (kk >= int'(v.f)) && (kk <= ls) && (((kk - int'(v.f)) % g) == 0);
            @(negedge clk);
            chk($sformatf("R2 v%0d k%0d ale%s", idx, k, sfx), 32'(bus_ale), 32'(k == -1));
            chk($sformatf("R8 v%0d k%0d drive%s", idx, k, sfx), 32'(bus_aout_en), 32'(k == -1));
            chk($sformatf("%s v%0d k%0d cs_n%s", (k <= 0) ? "R2" : "R7", idx, k, sfx),
                32'(bus_cs_n), 32'(!((k >= 0) && (k <= ls + int'(v.h)))));
            chk($sformatf("%s v%0d k%0d oe_n%s", (k > ls) ? "R6" : "R5", idx, k, sfx),
                32'(bus_oe_n), 32'(!((k >= 0) && (k >= int'(v.s)) && (k <= ls))));
            chk($sformatf("%s v%0d k%0d busy%s", (k > ls + m) ? "R10" : "R8", idx, k, sfx),
                32'(busy), 32'(exp_busy));
            chk($sformatf("%s v%0d k%0d rd_valid%s", (kk == int'(v.f)) ? "R3" : "R4", idx, k, sfx),
                32'(rd_valid), 32'(exp_vld));
            if (exp_vld)
                chk($sformatf("R3 v%0d k%0d rd_data%s", idx, k, sfx), 32'(rd_data), 32'(prev_d));
            if (k == -1) begin
                chk($sformatf("R2 v%0d aout%s", idx, sfx), 32'(bus_aout), 32'(v.addr));
                chk($sformatf("R2 v%0d lane%s", idx, sfx), 32'(bus_lane), 32'(v.addr[2:0]));
            end else if (k <= ls) begin
                chk($sformatf("R9 v%0d k%0d lane%s", idx, k, sfx), 32'(bus_lane),
                    32'(lane_exp(v, k)));
            end
            // inputs for the next edge
            prev_d  = DATA_W'(int'(prev_d) * 5 + k + 17);
            bus_din = prev_d;
            if (v.noise && exp_busy && (k < ls + m)) begin
                req_valid = 1'b1;
                req_addr  = ~v.addr;
                req_len   = '1;
                cfg_first = 8'd1; cfg_next = 8'd7; cfg_setup = 8'd0;
                cfg_hold  = 8'd9; cfg_turn = 8'd9; cfg_skew = 8'd0;
            end else begin
                req_valid = 1'b0;
            end
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 100000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", wd, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after release");

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i);

        // directed: reset in the middle of a burst
        req_valid = 1'b1; req_addr = 24'h000044; req_len = 4'd7;
        cfg_first = 8'd2; cfg_next = 8'd3; cfg_setup = 8'd1;
        cfg_hold = 8'd2; cfg_turn = 8'd4; cfg_skew = 8'd0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 busy before mid reset", 32'(busy), 32'd1);
        chk("R1 cs_n before mid reset", 32'(bus_cs_n), 32'd0);
        rst_n = 1'b0;
        #1;
        check_idle("R1 mid reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after mid reset");

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule